// File: doc/BRIEF.md
# Lane-Split Vector Element Broadcaster

This block fills a 256-bit destination vector with copies of one element taken from a source vector. Elements may be 8, 16, 32 or 64 bits wide, and a 128-bit element is also accepted when the source is element zero. Elements are numbered little-endian, so element 0 sits in the least significant bits.

There are two ways to choose the element by index. In both, each 128-bit half of the result is filled from the matching half of the source, so the upper half never sees lower-half data. One way takes the index from a 64-bit scalar operand and the other from a 4-bit immediate. A third mode copies element 0 of the whole source across the full result. A width select limits the result to its low 128 bits.

Each start pulse registers one result. A valid strobe is raised for exactly one cycle after it. Instruction decode and register-file access are handled elsewhere.

Top module: `vec_bcast`

## Requirements
- R1: After reset `dst_o` is all zeros and `valid_o` is 0.
- R2: A result is registered on every clock edge where `start_i` is 1, and `valid_o` is 1 for exactly the next cycle. With `start_i` at 0, `valid_o` drops to 0 and `dst_o` keeps its value.
- R3: Mode 0 (scalar index) reduces `idx_i` modulo the number of elements per 128-bit half, which is 16, 8, 4 or 2 for `esize_i` 0, 1, 2 or 3 (8, 16, 32, 64 bits). All higher index bits are ignored.
- R4: In modes 0 and 1 with `wide_i`=1, result bits [127:0] repeat element k of source bits [127:0]. Result bits [255:128] repeat element k of source bits [255:128].
- R5: Mode 1 (immediate) uses the low 4, 3, 2 or 1 bits of `imm_i` for `esize_i` 0, 1, 2 or 3, and ignores the other bits. The upper half uses element imm+count, where count is the per-half element count.
- R6: Mode 2 (element zero) repeats source element 0 across all result bits, including the upper half.
- R7: In mode 2 with `esize_i`=4 (128 bits), source bits [127:0] are copied into both result halves.
- R8: With `wide_i`=0, result bits [255:128] are zero and the lower half is formed as in the wide case.
- R9: Mode 3, `esize_i`=4 in modes 0 or 1, and `esize_i` values 5 to 7 all produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture a result this cycle |
| mode_i | input | 2 | 0 scalar index, 1 immediate, 2 element zero, 3 reserved |
| esize_i | input | 3 | Element size: 0 byte, 1 half, 2 word, 3 double, 4 quad |
| wide_i | input | 1 | 1 = 256-bit result, 0 = 128-bit result |
| src_i | input | 256 | Source vector |
| idx_i | input | 64 | Scalar index operand |
| imm_i | input | 4 | Immediate index |
| dst_o | output | 256 | Registered destination vector |
| valid_o | output | 1 | One-cycle strobe after each start |

## Verification
The bench sets the upper index and immediate bits to ones. A design that fails to mask them would select the wrong element or read past the half. A source pattern with a different byte value in every position catches a design that fills the upper half from the lower source half, or that fails to do so in element-zero mode. Quad size is tested both where it is legal and where it is not, and the narrow width is tested as well. These cases expose a missing duplication, upper bits that were not cleared, or a reserved code that is not forced to zero. A hold cycle after each result catches a strobe that stays high or an output that drifts.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_IMM  = 2'd1,
    MODE_ZERO = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ES_B = 3'd0,
    ES_H = 3'd1,
    ES_W = 3'd2,
    ES_D = 3'd3,
    ES_Q = 3'd4
  } esize_e;
endpackage

// File: rtl/vbc_pick.sv
module vbc_pick #(
  parameter int HALF_W = 128,
  parameter int IDX_W  = 4
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic [2:0]        esize_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [HALF_W-1:0] elem_o
);
  import vbc_pkg::*;
  localparam int SH_W = $clog2(HALF_W);

  logic [SH_W-1:0]   sh_amt;
  logic [HALF_W-1:0] shifted;

  always_comb begin
    sh_amt  = SH_W'(sel_i) << (esize_i + 3'd3);
    shifted = half_i >> sh_amt;
    elem_o  = '0;
    case (esize_e'(esize_i))
      ES_B:    elem_o[7:0]  = shifted[7:0];
      ES_H:    elem_o[15:0] = shifted[15:0];
      ES_W:    elem_o[31:0] = shifted[31:0];
      ES_D:    elem_o[63:0] = shifted[63:0];
      ES_Q:    elem_o       = half_i;
      default: elem_o       = '0;
    endcase
  end
endmodule

// File: rtl/vbc_splat.sv
module vbc_splat #(
  parameter int HALF_W = 128
) (
  input  logic [HALF_W-1:0] elem_i,
  input  logic [2:0]        esize_i,
  output logic [HALF_W-1:0] rep_o
);
  import vbc_pkg::*;

  always_comb begin
    case (esize_e'(esize_i))
      ES_B:    rep_o = {(HALF_W/8){elem_i[7:0]}};
      ES_H:    rep_o = {(HALF_W/16){elem_i[15:0]}};
      ES_W:    rep_o = {(HALF_W/32){elem_i[31:0]}};
      ES_D:    rep_o = {(HALF_W/64){elem_i[63:0]}};
      ES_Q:    rep_o = elem_i;
      default: rep_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_bcast.sv
module vec_bcast #(
  parameter int VEC_W = 256,
  parameter int XLEN  = 64,
  parameter int IMM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [2:0]       esize_i,
  input  logic             wide_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [XLEN-1:0]  idx_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             valid_o
);
  import vbc_pkg::*;

  localparam int HALF_W = VEC_W / 2;
  localparam int NHALF  = VEC_W / HALF_W;
  localparam int IDX_W  = $clog2(HALF_W / 8);

  logic [IDX_W:0]   per_half_cnt;
  logic [IDX_W-1:0] idx_mask;
  logic [IDX_W-1:0] sel;
  logic             kill;
  logic [VEC_W-1:0] res;

  // Per-half element count minus one masks the index
  always_comb begin
    per_half_cnt = (IDX_W+1)'(HALF_W / 8) >> esize_i;
    idx_mask     = IDX_W'(per_half_cnt - 1'b1);
    case (mode_e'(mode_i))
      MODE_REG: sel = idx_i[IDX_W-1:0] & idx_mask;
      MODE_IMM: sel = IDX_W'(imm_i) & idx_mask;
      default:  sel = '0;
    endcase
    kill = (mode_e'(mode_i) == MODE_RSVD) || (esize_i > ES_Q) ||
           ((esize_e'(esize_i) == ES_Q) && (mode_e'(mode_i) != MODE_ZERO));
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] half_src;
    logic [HALF_W-1:0] elem;
    logic [HALF_W-1:0] rep;

    // Element-zero mode reads the low half for every lane
    assign half_src = (mode_e'(mode_i) == MODE_ZERO) ? src_i[HALF_W-1:0]
                                                      : src_i[h*HALF_W +: HALF_W];

    vbc_pick #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_pick (
      .half_i (half_src),
      .esize_i(esize_i),
      .sel_i  (sel),
      .elem_o (elem)
    );

    vbc_splat #(.HALF_W(HALF_W)) u_splat (
      .elem_i (elem),
      .esize_i(esize_i),
      .rep_o  (rep)
    );

    assign res[h*HALF_W +: HALF_W] = (kill || (h > 0 && !wide_i)) ? '0 : rep;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) dst_o <= res;
    end
  end
endmodule

// File: rtl/vec_bcast_chk.sv
module vec_bcast_chk #(
  parameter int VEC_W = 256,
  parameter int XLEN  = 64,
  parameter int IMM_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic [2:0]       esize_i,
  input logic             wide_i,
  input logic [VEC_W-1:0] src_i,
  input logic [XLEN-1:0]  idx_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [VEC_W-1:0] dst_o,
  input logic             valid_o
);
  localparam int HW = VEC_W / 2;

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!valid_o && dst_o == '0);
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  p_valid_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(dst_o));

  p_lane_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 2'd0 && esize_i == 3'd3 && wide_i) |=>
      dst_o[HW +: 64] == (idx_i[0] ? $past(src_i[VEC_W-64 +: 64]) : $past(src_i[HW +: 64])));

  p_elem_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 2'd2 && esize_i == 3'd0 && wide_i) |=>
      (dst_o[7:0] == $past(src_i[7:0]) && dst_o[VEC_W-1 -: 8] == $past(src_i[7:0])));

  p_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wide_i) |=> dst_o[VEC_W-1:HW] == '0);

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 2'd3) |=> dst_o == '0);
endmodule

bind vec_bcast vec_bcast_chk #(.VEC_W(VEC_W), .XLEN(XLEN), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/vec_bcast_test.sv
module vec_bcast_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = '0;
  logic [2:0]   esize = '0;
  logic         wide = 1'b1;
  logic [255:0] src = '0;
  logic [63:0]  idx = '0;
  logic [3:0]   imm = '0;
  logic [255:0] dst;
  logic         valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vec_bcast uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .esize_i(esize), .wide_i(wide), .src_i(src), .idx_i(idx),
    .imm_i(imm), .dst_o(dst), .valid_o(valid)
  );

  function automatic logic [255:0] model(input logic [255:0] s, input int md,
                                         input int es, input bit wd,
                                         input logic [63:0] ix, input logic [3:0] im);
    logic [255:0] r = '0;
    int w, n, k, base;
    if (md == 3 || es > 4 || (es == 4 && md != 2)) return r;
    w = 8 << es;
    n = 128 / w;
    for (int h = 0; h < 2; h++) begin
      if (h == 1 && !wd) continue;
      if (md == 0) k = int'(ix % 64'(n));
      else if (md == 1) k = int'(im) % n;
      else k = 0;
      base = (md == 2) ? 0 : h * 128;
      for (int e = 0; e < n; e++)
        for (int b = 0; b < w; b++)
          r[h*128 + e*w + b] = s[base + k*w + b];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input int md, input int es, input bit wd,
                     input logic [63:0] ix, input logic [3:0] im);
    logic [255:0] exp;
    @(negedge clk);
    mode = md[1:0]; esize = es[2:0]; wide = wd; idx = ix; imm = im; start = 1'b1;
    exp = model(src, md, es, wd, ix, im);
    @(negedge clk);
    start = 1'b0;
    chk({req, " valid"}, {255'd0, valid}, 256'd1);
    chk(req, dst, exp);
    @(negedge clk);
    chk("R2 valid low", {255'd0, valid}, 256'd0);
    chk("R2 hold", dst, exp);
  endtask

  task automatic t_reset();
    chk("R1 dst", dst, '0);
    chk("R1 valid", {255'd0, valid}, 256'd0);
  endtask

  task automatic t_reg_mode();
    for (int es = 0; es < 4; es++) begin
      run("R3 reg idx", 0, es, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0 | 64'(es + 1), 4'h0);
      run("R4 lane split", 0, es, 1'b1, 64'h8000_0000_0000_0003, 4'h0);
    end
  endtask

  task automatic t_imm_mode();
    for (int es = 0; es < 4; es++) begin
      run("R5 imm high", 1, es, 1'b1, 64'h0, 4'hF);
      run("R5 imm low", 1, es, 1'b1, 64'h0, 4'h1);
    end
  endtask

  task automatic t_zero_mode();
    for (int es = 0; es < 4; es++) run("R6 elem zero", 2, es, 1'b1, 64'h5, 4'h7);
    run("R7 quad dup", 2, 4, 1'b1, 64'h0, 4'h0);
  endtask

  task automatic t_narrow();
    run("R8 narrow reg", 0, 1, 1'b0, 64'h6, 4'h0);
    run("R8 narrow imm", 1, 0, 1'b0, 64'h0, 4'hB);
    run("R8 narrow quad", 2, 4, 1'b0, 64'h0, 4'h0);
  endtask

  task automatic t_illegal();
    run("R9 quad reg", 0, 4, 1'b1, 64'h1, 4'h0);
    run("R9 quad imm", 1, 4, 1'b1, 64'h0, 4'h1);
    run("R9 rsvd mode", 3, 0, 1'b1, 64'h2, 4'h2);
    run("R9 bad size", 0, 6, 1'b1, 64'h2, 4'h0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) src[i*8 +: 8] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_mode();
    t_imm_mode();
    t_zero_mode();
    t_narrow();
    t_illegal();
    for (int i = 0; i < 32; i++) src[i*8 +: 8] = 8'(255 - i * 5);
    run("R4 lane split alt", 0, 2, 1'b1, 64'h7, 4'h0);
    run("R6 elem zero alt", 2, 3, 1'b1, 64'h1, 4'h1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule